// File: doc/BRIEF.md
# System Call Trap Entry Unit

This unit handles interrupt entry for the system-call instruction on a small 64-bit core with no hypervisor mode. When a valid instruction arrives, it checks whether the word encodes a system call and reads its level field. It then picks one of two outcomes: a normal system-call trap, or an illegal-instruction (program) trap for reserved levels. A build-time parameter decides whether reserved levels take the program trap or are folded into a plain system call.

One cycle after the instruction, the unit produces four results. It pulses a fetch redirect, presents the vector as the new program counter, and loads the two save/restore registers with the return address and the old machine state. It also presents the handler's machine state. That state is built from the old value: a fixed set of fields is forced, and every other bit is kept. The forced fields include the trace-enable pair and the floating-point exception-mode bits, so that no trace or floating-point interrupt can fire inside the first-level handler.

Top module: `sc_trap_entry`

## Requirements
- R1: A system call is an instruction word with bits [31:26] equal to 17 and bit 1 set. With any other word, a valid strobe leaves `redirect_o` at 0 and leaves `srr0_o` and `srr1_o` unchanged.
- R2: A system call with level field (bits [11:5]) equal to 0 or 1 redirects to vector 0xC00, and `srr0_o` becomes the instruction's PC + 4 (modulo 2^64). Level 1 is handled exactly like level 0.
- R3: With `TRAP_RESERVED_LEV`=1 (the default), a system call with level 2..127 redirects to vector 0x700. In that case `srr0_o` becomes the instruction's own PC, and `srr1_o` becomes the old MSR with bit 19 (illegal-instruction reason) set.
- R4: With `TRAP_RESERVED_LEV`=0, a system call with level 2..127 behaves exactly like level 0.
- R5: The new MSR has bit 63 (64-bit mode) and bit 0 (little-endian) set.
- R6: The new MSR has these bits cleared:
  - 15 (external interrupt enable), 14 (problem state) and 13 (FP available)
  - 5 and 4 (instruction and data relocate), and 1 (recoverable)
  - 58 (reserved bit), 32 (transactional), 25 (vector) and 23 (VSX)
  - 2 (perf-monitor mark)
  - 10 and 9 (trace-enable pair)
  - 11 and 8 (FP exception mode)
- R7: Every other MSR bit of the new MSR equals the old MSR, including bit 60 (hypervisor), which is never set by entry.
- R8: For a system call, `srr1_o` equals the old MSR unchanged.
- R9: `redirect_o`, `new_pc_o`, `new_msr_o`, `srr0_o` and `srr1_o` update in the single cycle after the valid strobe, and `redirect_o` stays high for one cycle per accepted instruction.
- R10: An active-low reset clears `redirect_o`, `new_pc_o`, `new_msr_o`, `srr0_o` and `srr1_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| insn_vld_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| msr_i | input | 64 | Current machine state register |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| new_pc_o | output | 64 | Handler vector address |
| new_msr_o | output | 64 | Machine state for the handler |
| srr0_o | output | 64 | Saved return address |
| srr1_o | output | 64 | Saved machine state |

## Verification
The hardest case to reach from the ports is the split between folded and trapping reserved levels. Both builds must agree on levels 0 and 1 and disagree on every level from 2 to 127, for any machine state. The bench therefore runs two instances side by side, one per setting of the parameter, and drives both with the same stimulus. It sweeps all 128 level values under four machine-state patterns, from all zeros to all ones, so every forced and kept bit is seen in both directions. It also sweeps all 64 primary opcodes with bit 1 both clear and set, and confirms that the save registers keep their previous contents for every non-system-call word.

// File: rtl/sc_trap_pkg.sv
package sc_trap_pkg;

  localparam int MSR_W = 64;

  // machine state bit positions, bit 0 = least significant
  localparam int B_SF   = 63;
  localparam int B_HV   = 60;
  localparam int B_RSV5 = 58;
  localparam int B_TM   = 32;
  localparam int B_VEC  = 25;
  localparam int B_VSX  = 23;
  localparam int B_EE   = 15;
  localparam int B_PR   = 14;
  localparam int B_FP   = 13;
  localparam int B_FE0  = 11;
  localparam int B_TE1  = 10;
  localparam int B_TE0  = 9;
  localparam int B_FE1  = 8;
  localparam int B_IR   = 5;
  localparam int B_DR   = 4;
  localparam int B_PMM  = 2;
  localparam int B_RI   = 1;
  localparam int B_LE   = 0;
  localparam int B_ILLEGAL_REASON = 19;

  typedef enum logic [1:0] {
    ENT_NONE    = 2'd0,
    ENT_SYSCALL = 2'd1,
    ENT_ILLEGAL = 2'd2
  } entry_kind_e;

  function automatic logic [MSR_W-1:0] entry_clear_mask();
    logic [MSR_W-1:0] m;
    m = '0;
    m[B_RSV5] = 1'b1; m[B_TM]  = 1'b1; m[B_VEC] = 1'b1; m[B_VSX] = 1'b1;
    m[B_EE]   = 1'b1; m[B_PR]  = 1'b1; m[B_FP]  = 1'b1; m[B_FE0] = 1'b1;
    m[B_TE1]  = 1'b1; m[B_TE0] = 1'b1; m[B_FE1] = 1'b1; m[B_IR]  = 1'b1;
    m[B_DR]   = 1'b1; m[B_PMM] = 1'b1; m[B_RI]  = 1'b1;
    return m;
  endfunction

  function automatic logic [MSR_W-1:0] entry_set_mask();
    logic [MSR_W-1:0] m;
    m = '0;
    m[B_SF] = 1'b1;
    m[B_LE] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/sc_lev_decode.sv
module sc_lev_decode
  import sc_trap_pkg::*;
#(
  parameter int INSN_W            = 32,
  parameter int SC_OPCODE         = 17,
  parameter int LEV_W             = 7,
  parameter int LEV_LSB           = 5,
  parameter bit TRAP_RESERVED_LEV = 1'b1
) (
  input  logic              vld_i,
  input  logic [INSN_W-1:0] insn_i,
  output entry_kind_e       kind_o
);
  localparam int OPC_W   = 6;
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int SC_BIT  = 1;

  logic             is_sc;
  logic [LEV_W-1:0] lev;
  logic             lev_reserved;

  assign lev          = insn_i[LEV_LSB +: LEV_W];
  assign is_sc        = vld_i
                      && (insn_i[OPC_LSB +: OPC_W] == OPC_W'(SC_OPCODE))
                      && insn_i[SC_BIT];
  assign lev_reserved = (lev > LEV_W'(1));

  generate
    if (TRAP_RESERVED_LEV) begin : g_trap
      always_comb begin
        if (!is_sc)            kind_o = ENT_NONE;
        else if (lev_reserved) kind_o = ENT_ILLEGAL;
        else                   kind_o = ENT_SYSCALL;
      end
    end else begin : g_fold
      logic unused_res;
      assign unused_res = lev_reserved;
      always_comb begin
        kind_o = is_sc ? ENT_SYSCALL : ENT_NONE;
      end
    end
  endgenerate
endmodule

// File: rtl/sc_msr_recipe.sv
module sc_msr_recipe
  import sc_trap_pkg::*;
(
  input  entry_kind_e      kind_i,
  input  logic [MSR_W-1:0] old_msr_i,
  output logic [MSR_W-1:0] new_msr_o,
  output logic [MSR_W-1:0] saved_msr_o
);
  localparam logic [MSR_W-1:0] CLR_MASK = entry_clear_mask();
  localparam logic [MSR_W-1:0] SET_MASK = entry_set_mask();

  always_comb begin
    new_msr_o   = (old_msr_i & ~CLR_MASK) | SET_MASK;
    saved_msr_o = old_msr_i;
    if (kind_i == ENT_ILLEGAL) saved_msr_o[B_ILLEGAL_REASON] = 1'b1;
  end
endmodule

// File: rtl/sc_entry_regs.sv
module sc_entry_regs #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic [W-1:0] pc_d,
  input  logic [W-1:0] msr_d,
  input  logic [W-1:0] srr0_d,
  input  logic [W-1:0] srr1_d,
  output logic         redirect_q,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] msr_q,
  output logic [W-1:0] srr0_q,
  output logic [W-1:0] srr1_q
);
  logic         redirect_nx;
  logic [W-1:0] pc_nx, msr_nx, srr0_nx, srr1_nx;

  always_comb begin
    redirect_nx = take_i;
    pc_nx       = pc_q;
    msr_nx      = msr_q;
    srr0_nx     = srr0_q;
    srr1_nx     = srr1_q;
    if (take_i) begin
      pc_nx   = pc_d;
      msr_nx  = msr_d;
      srr0_nx = srr0_d;
      srr1_nx = srr1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_q <= 1'b0;
      pc_q       <= '0;
      msr_q      <= '0;
      srr0_q     <= '0;
      srr1_q     <= '0;
    end else begin
      redirect_q <= redirect_nx;
      pc_q       <= pc_nx;
      msr_q      <= msr_nx;
      srr0_q     <= srr0_nx;
      srr1_q     <= srr1_nx;
    end
  end
endmodule

// File: rtl/sc_trap_entry.sv
module sc_trap_entry
  import sc_trap_pkg::*;
#(
  parameter int             PC_W              = 64,
  parameter int             INSN_W            = 32,
  parameter bit             TRAP_RESERVED_LEV = 1'b1,
  parameter logic [PC_W-1:0] SC_VECTOR        = 64'h0000_0000_0000_0C00,
  parameter logic [PC_W-1:0] PROG_VECTOR      = 64'h0000_0000_0000_0700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_vld_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [MSR_W-1:0]  msr_i,
  output logic              redirect_o,
  output logic [PC_W-1:0]   new_pc_o,
  output logic [MSR_W-1:0]  new_msr_o,
  output logic [PC_W-1:0]   srr0_o,
  output logic [MSR_W-1:0]  srr1_o
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(INSN_W / 8);

  entry_kind_e      kind;
  logic             take;
  logic [PC_W-1:0]  vec_d, srr0_d;
  logic [MSR_W-1:0] msr_d, srr1_d;

  sc_lev_decode #(
    .INSN_W           (INSN_W),
    .TRAP_RESERVED_LEV(TRAP_RESERVED_LEV)
  ) u_dec (
    .vld_i (insn_vld_i),
    .insn_i(insn_i),
    .kind_o(kind)
  );

  sc_msr_recipe u_msr (
    .kind_i     (kind),
    .old_msr_i  (msr_i),
    .new_msr_o  (msr_d),
    .saved_msr_o(srr1_d)
  );

  always_comb begin
    take   = (kind != ENT_NONE);
    vec_d  = SC_VECTOR;
    srr0_d = pc_i + INSN_BYTES;
    if (kind == ENT_ILLEGAL) begin
      vec_d  = PROG_VECTOR;
      srr0_d = pc_i;
    end
  end

  sc_entry_regs #(.W(PC_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take),
    .pc_d      (vec_d),
    .msr_d     (msr_d),
    .srr0_d    (srr0_d),
    .srr1_d    (srr1_d),
    .redirect_q(redirect_o),
    .pc_q      (new_pc_o),
    .msr_q     (new_msr_o),
    .srr0_q    (srr0_o),
    .srr1_q    (srr1_o)
  );
endmodule

// File: rtl/sc_trap_entry_chk.sv
module sc_trap_entry_chk
  import sc_trap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             insn_vld_i,
  input logic             redirect_o,
  input logic [63:0]      new_pc_o,
  input logic [MSR_W-1:0] new_msr_o,
  input logic [63:0]      srr0_o,
  input logic [MSR_W-1:0] srr1_o
);
  localparam logic [MSR_W-1:0] CLR = entry_clear_mask();

  // R9: a redirect needs a valid strobe in the cycle before
  p_redirect_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> $past(insn_vld_i));

  // R1: no valid strobe, save registers hold
  p_srr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld_i |=> ($stable(srr0_o) && $stable(srr1_o)));

  // R2: only the two vectors are ever targeted
  p_vector_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (new_pc_o == 64'hC00 || new_pc_o == 64'h700));

  // R5
  p_msr_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (new_msr_o[B_SF] && new_msr_o[B_LE]));

  // R6
  p_msr_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> ((new_msr_o & CLR) == '0));

  // R7: hypervisor bit passes through from the saved state
  p_hv_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (new_msr_o[B_HV] == srr1_o[B_HV]));

  // R3: program vector always carries the reason bit
  p_prog_reason_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && new_pc_o == 64'h700) |-> srr1_o[B_ILLEGAL_REASON]);
endmodule

bind sc_trap_entry sc_trap_entry_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_vld_i(insn_vld_i),
  .redirect_o(redirect_o),
  .new_pc_o  (new_pc_o),
  .new_msr_o (new_msr_o),
  .srr0_o    (srr0_o),
  .srr1_o    (srr1_o)
);

// File: tb/sc_trap_entry_tb.sv
module sc_trap_entry_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld;
  logic [31:0] insn;
  logic [63:0] pc, msr;

  logic        rd_a, rd_b;
  logic [63:0] npc_a, nmsr_a, s0_a, s1_a;
  logic [63:0] npc_b, nmsr_b, s0_b, s1_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;  // 250 MHz

  sc_trap_entry u_dut (
    .clk(clk), .rst_n(rst_n), .insn_vld_i(vld), .insn_i(insn), .pc_i(pc), .msr_i(msr),
    .redirect_o(rd_a), .new_pc_o(npc_a), .new_msr_o(nmsr_a), .srr0_o(s0_a), .srr1_o(s1_a));

  sc_trap_entry #(.TRAP_RESERVED_LEV(1'b0)) u_dut_fold (
    .clk(clk), .rst_n(rst_n), .insn_vld_i(vld), .insn_i(insn), .pc_i(pc), .msr_i(msr),
    .redirect_o(rd_b), .new_pc_o(npc_b), .new_msr_o(nmsr_b), .srr0_o(s0_b), .srr1_o(s1_b));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_msr(input logic [63:0] m);
    logic [63:0] r;
    int clr[15] = '{58, 32, 25, 23, 15, 14, 13, 11, 10, 9, 8, 5, 4, 2, 1};
    r = m;
    foreach (clr[i]) r[clr[i]] = 1'b0;
    r[63] = 1'b1;
    r[0]  = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] sc_word(input int lev);
    return (32'd17 << 26) | (32'(lev) << 5) | 32'd2;
  endfunction

  // one system call on both instances
  task automatic issue_sc(input int lev, input logic [63:0] p, input logic [63:0] m);
    logic trap_a;
    trap_a = (lev > 1);
    @(negedge clk);
    vld = 1'b1; insn = sc_word(lev); pc = p; msr = m;
    @(negedge clk);
    vld = 1'b0;
    chk(64'(rd_a), 64'd1, "R9 redirect");
    chk(nmsr_a, exp_msr(m), "R5/R6/R7 new msr");
    if (trap_a) begin
      chk(npc_a, 64'h700, "R3 vector");
      chk(s0_a, p, "R3 srr0");
      chk(s1_a, m | (64'd1 << 19), "R3 srr1");
    end else begin
      chk(npc_a, 64'hC00, "R2 vector");
      chk(s0_a, p + 64'd4, "R2 srr0");
      chk(s1_a, m, "R8 srr1");
    end
    chk(64'(rd_b), 64'd1, "R4 redirect");
    chk(npc_b, 64'hC00, "R4 vector");
    chk(s0_b, p + 64'd4, "R4 srr0");
    chk(s1_b, m, "R4 srr1");
    chk(nmsr_b, exp_msr(m), "R4 new msr");
    @(negedge clk);
    chk(64'(rd_a), 64'd0, "R9 pulse width");
  endtask

  task automatic issue_other(input logic [31:0] w);
    logic [63:0] p0, p1;
    p0 = s0_a; p1 = s1_a;
    @(negedge clk);
    vld = 1'b1; insn = w; pc = 64'h0000_0000_0BAD_0000; msr = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    vld = 1'b0;
    chk(64'(rd_a), 64'd0, "R1 no redirect");
    chk(s0_a, p0, "R1 srr0 kept");
    chk(s1_a, p1, "R1 srr1 kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats[4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                             64'hA5A5_A5A5_A5A5_A5A5, 64'h5A5A_5A5A_5A5A_5A5A};
    rst_n = 1'b0; vld = 1'b0; insn = '0; pc = '0; msr = '0;
    repeat (3) @(negedge clk);
    chk(64'(rd_a), 64'd0, "R10 redirect");
    chk(npc_a, 64'd0, "R10 new pc");
    chk(nmsr_a, 64'd0, "R10 new msr");
    chk(s0_a, 64'd0, "R10 srr0");
    chk(s1_a, 64'd0, "R10 srr1");
    rst_n = 1'b1;

    foreach (pats[k]) begin
      for (int lev = 0; lev < 128; lev++)
        issue_sc(lev, 64'h0000_0001_0000_0000 + 64'(lev * 4 + k * 1024), pats[k]);
    end
    issue_sc(1, 64'hFFFF_FFFF_FFFF_FFFC, 64'h1000_0000_0000_0000);  // R2 wrap, R7 hv kept
    issue_sc(5, 64'hFFFF_FFFF_FFFF_FFFC, 64'h1000_0000_0000_0000);

    for (int op = 0; op < 64; op++) begin
      for (int b1 = 0; b1 < 2; b1++) begin
        if (!(op == 17 && b1 == 1))
          issue_other((32'(op) << 26) | (32'(b1) << 1) | 32'h0000_0FE0);
      end
    end

    // R10: reset after state was loaded
    issue_sc(0, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(s0_a, 64'd0, "R10 srr0 after load");
    chk(s1_a, 64'd0, "R10 srr1 after load");
    chk(npc_a, 64'd0, "R10 new pc after load");
    rst_n = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule